// File: doc/BRIEF.md
# Indirect Port Window for Byte-Wide Non-Volatile Memory

This block puts a byte-wide memory behind a window of four byte ports. The host never drives the memory address directly. It loads a 16-bit address latch, high and low bytes through two separate ports, and then moves a byte through the data port. A data write stores the byte at the latched address and returns the latch to zero. A data read leaves the latch where it was, so the same location can be polled again without reloading the address.

Two lock bits each guard a fixed 16-byte window at the bottom of the address space. Each lock bit is inverted by a pulse on its toggle input. While a lock is set, reads of its window return all ones and writes there are dropped without any indication. The top sixteen addresses are reserved for timekeeping. In this block only two of them behave differently from plain storage: the flags location and the one just above it. Both read as zero and cannot be written. Read data is registered and appears one cycle after the read strobe, together with a valid pulse.

Top module: `nvram_window`

## Requirements
- R1: A write to port 0 replaces bits 7:0 of the address latch and a write to port 1 replaces bits 15:8. The other byte of the latch is kept.
- R2: A write to port 3 stores the data byte at the latched address, then clears the latch to 0x0000.
- R3: A read of port 3 sets `rd_valid` for exactly one cycle, in the cycle after the strobe, and `rd_data` then holds the byte at the latched address. The latch does not change.
- R4: Reads of ports 0, 1 and 2 return 0xFF one cycle later, with `rd_valid` set. A write to port 2 changes neither the memory nor the latch.
- R5: While lock bit 0 is set, addresses 0x0020 to 0x002F read as 0xFF and writes to them are dropped. Addresses 0x001F and 0x0030 are not affected.
- R6: While lock bit 1 is set, addresses 0x0030 to 0x003F read as 0xFF and writes to them are dropped. Addresses 0x002F and 0x0040 are not affected.
- R7: A high `lock_toggle[i]` on a clock edge inverts lock bit i. An access in that same cycle is judged with the lock value from before the toggle.
- R8: An address at or above `MEM_BYTES` reads as 0xFF, and writes to it are dropped.
- R9: Address `MEM_BYTES-16` (flags) and address `MEM_BYTES-15` read as 0x00, and writes to them are dropped. Address `MEM_BYTES-17` is plain storage.
- R10: Reset clears the address latch, both lock bits and `rd_valid`. It does not clear the memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_sel | input | 1 | Access strobe, one access per cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_port | input | 2 | Port offset: 0 address low, 1 address high, 2 unused, 3 data |
| acc_wdata | input | 8 | Write byte |
| lock_toggle | input | 2 | Per-lock invert pulse |
| rd_data | output | 8 | Read byte, valid when rd_valid is set |
| rd_valid | output | 1 | One-cycle pulse one cycle after a read strobe |

## Verification
The address latch and the lock bits cannot be read at the ports, so a wrong value in either shows up only at the next data access. The bench therefore pairs every latch update with a later data read or write, whose result reveals the latch one or two accesses afterwards. If a latch fails to clear after a data write, the following write without an address lands in the wrong byte, and a later read of that byte shows it. A lock bit left in the wrong state shows up as 0xFF, or as a stored byte, on the first read of its window. The windows are probed at both edges, so an off-by-one in the window bounds reads back wrong at once.

// File: rtl/nvw_pkg.sv
package nvw_pkg;

    // how the registered read result is formed in the cycle after a read strobe
    typedef enum logic [1:0] {
        RK_MEM  = 2'd0,
        RK_ONES = 2'd1,
        RK_ZERO = 2'd2
    } rd_kind_e;

    localparam logic [1:0] PORT_ADDR_LO = 2'd0;
    localparam logic [1:0] PORT_ADDR_HI = 2'd1;
    localparam logic [1:0] PORT_DATA    = 2'd3;

    typedef struct packed {
        logic [15:0] addr;
        logic [1:0]  lock;
        rd_kind_e    kind;
        logic        rvalid;
    } nvw_state_t;

endpackage

// File: rtl/nvw_classify.sv
module nvw_classify
    import nvw_pkg::*;
#(
    parameter int MEM_BYTES = 2048,
    parameter int NUM_LOCKS = 2,
    parameter int LOCK_BASE = 32,
    parameter int LOCK_SPAN = 16
) (
    input  logic [15:0]          addr,
    input  logic [NUM_LOCKS-1:0] lock,
    output rd_kind_e             kind
);
    localparam logic [16:0] LIMIT    = 17'(MEM_BYTES);
    localparam logic [15:0] FLAG_LOC = 16'(MEM_BYTES - 16);
    localparam logic [15:0] ZERO_LOC = 16'(MEM_BYTES - 15);

    logic [NUM_LOCKS-1:0] hit;

    for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_win
        localparam logic [16:0] LO = 17'(LOCK_BASE + i * LOCK_SPAN);
        localparam logic [16:0] HI = 17'(LOCK_BASE + (i + 1) * LOCK_SPAN);
        assign hit[i] = lock[i] && ({1'b0, addr} >= LO) && ({1'b0, addr} < HI);
    end

    always_comb begin
        if ({1'b0, addr} >= LIMIT) begin
            kind = RK_ONES;
        end else if (addr == FLAG_LOC || addr == ZERO_LOC) begin
            kind = RK_ZERO;
        end else if (|hit) begin
            kind = RK_ONES;
        end else begin
            kind = RK_MEM;
        end
    end

endmodule

// File: rtl/nvw_store.sv
module nvw_store #(
    parameter int MEM_BYTES = 2048,
    localparam int AW = $clog2(MEM_BYTES)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] idx,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] cells [MEM_BYTES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[idx] <= wdata;
        end
        if (rd_en) begin
            rdata <= cells[idx];
        end
    end

endmodule

// File: rtl/nvram_window.sv
module nvram_window
    import nvw_pkg::*;
#(
    parameter int MEM_BYTES = 2048,
    parameter int NUM_LOCKS = 2,
    parameter int LOCK_BASE = 32,
    parameter int LOCK_SPAN = 16,
    localparam int AW = $clog2(MEM_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_sel,
    input  logic                 acc_we,
    input  logic [1:0]           acc_port,
    input  logic [7:0]           acc_wdata,
    input  logic [NUM_LOCKS-1:0] lock_toggle,
    output logic [7:0]           rd_data,
    output logic                 rd_valid
);
    nvw_state_t st_d, st_q;
    rd_kind_e   cls_kind;
    logic       data_acc;
    logic       mem_wr, mem_rd;
    logic [7:0] mem_q;
    logic [15:0]          latch_q;
    logic [NUM_LOCKS-1:0] lock_q;

    nvw_classify #(
        .MEM_BYTES(MEM_BYTES),
        .NUM_LOCKS(NUM_LOCKS),
        .LOCK_BASE(LOCK_BASE),
        .LOCK_SPAN(LOCK_SPAN)
    ) cls_i (
        .addr(st_q.addr),
        .lock(st_q.lock),
        .kind(cls_kind)
    );

    assign data_acc = acc_sel && (acc_port == PORT_DATA);
    assign mem_wr   = data_acc && acc_we && (cls_kind == RK_MEM);
    assign mem_rd   = data_acc && !acc_we && (cls_kind == RK_MEM);

    nvw_store #(.MEM_BYTES(MEM_BYTES)) store_i (
        .clk  (clk),
        .wr_en(mem_wr),
        .rd_en(mem_rd),
        .idx  (st_q.addr[AW-1:0]),
        .wdata(acc_wdata),
        .rdata(mem_q)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        st_d.lock   = st_q.lock ^ lock_toggle;
        if (acc_sel) begin
            if (acc_we) begin
                case (acc_port)
                    PORT_ADDR_LO: st_d.addr[7:0]  = acc_wdata;
                    PORT_ADDR_HI: st_d.addr[15:8] = acc_wdata;
                    PORT_DATA:    st_d.addr       = 16'h0000;
                    default:      st_d.addr       = st_q.addr;
                endcase
            end else begin
                st_d.rvalid = 1'b1;
                st_d.kind   = (acc_port == PORT_DATA) ? cls_kind : RK_ONES;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{addr: 16'h0000, lock: '0, kind: RK_ONES, rvalid: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (st_q.kind)
            RK_MEM:  rd_data = mem_q;
            RK_ZERO: rd_data = 8'h00;
            default: rd_data = 8'hFF;
        endcase
    end

    assign rd_valid = st_q.rvalid;
    assign latch_q  = st_q.addr;
    assign lock_q   = st_q.lock;

endmodule

// File: rtl/nvw_checker.sv
module nvw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_sel,
    input logic        acc_we,
    input logic [1:0]  acc_port,
    input logic [7:0]  acc_wdata,
    input logic [1:0]  lock_toggle,
    input logic [15:0] latch_q,
    input logic [1:0]  lock_q,
    input logic [7:0]  rd_data,
    input logic        rd_valid
);
    assert_lo_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel && acc_we && acc_port == 2'd0) |=>
        (latch_q[7:0] == $past(acc_wdata) && latch_q[15:8] == $past(latch_q[15:8])));

    assert_hi_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel && acc_we && acc_port == 2'd1) |=>
        (latch_q[15:8] == $past(acc_wdata) && latch_q[7:0] == $past(latch_q[7:0])));

    assert_wr_clears_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel && acc_we && acc_port == 2'd3) |=> (latch_q == 16'h0000));

    assert_rd_keeps_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel && !acc_we) |=> $stable(latch_q));

    assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel && !acc_we) |=> rd_valid);

    assert_no_spurious_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_sel && !acc_we) |=> !rd_valid);

    assert_side_port_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel && !acc_we && acc_port != 2'd3) |=> (rd_data == 8'hFF));

    assert_spare_wr_inert_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel && acc_we && acc_port == 2'd2) |=> $stable(latch_q));

    assert_lock_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lock_q == ($past(lock_q) ^ $past(lock_toggle))));

endmodule

bind nvram_window nvw_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_sel    (acc_sel),
    .acc_we     (acc_we),
    .acc_port   (acc_port),
    .acc_wdata  (acc_wdata),
    .lock_toggle(lock_toggle),
    .latch_q    (latch_q),
    .lock_q     (lock_q),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid)
);

// File: tb/nvram_window_tb_top.sv
module nvram_window_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MEM = 2048;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_sel = 1'b0;
    logic       acc_we = 1'b0;
    logic [1:0] acc_port = 2'd0;
    logic [7:0] acc_wdata = 8'd0;
    logic [1:0] lock_toggle = 2'd0;
    logic [7:0] rd_data;
    logic       rd_valid;

    int n_checks = 0;
    int n_fail = 0;

    int         m_addr = 0;
    bit [1:0]   m_lock = 2'b00;
    logic [7:0] m_mem [int];

    always #(CLK_PERIOD / 2) clk = ~clk;

    nvram_window #(.MEM_BYTES(MEM)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_sel(acc_sel), .acc_we(acc_we),
        .acc_port(acc_port), .acc_wdata(acc_wdata), .lock_toggle(lock_toggle),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // 0 = storage, 1 = reads all ones, 2 = reads zero
    function automatic int m_class(int a);
        if (a >= MEM) return 1;
        if (a == MEM - 16 || a == MEM - 15) return 2;
        if (m_lock[0] && a >= 32 && a <= 47) return 1;
        if (m_lock[1] && a >= 48 && a <= 63) return 1;
        return 0;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic acc(input logic [1:0] port, input bit we, input logic [7:0] wd,
                       input logic [1:0] tgl, input string req);
        bit         exp_v = !we;
        bit         known = 1'b1;
        logic [7:0] exp_d = 8'hFF;
        int         c = m_class(m_addr);
        if (!we && port == 2'd3) begin
            if (c == 2) exp_d = 8'h00;
            else if (c == 0) begin
                if (m_mem.exists(m_addr)) exp_d = m_mem[m_addr];
                else known = 1'b0;
            end
        end
        acc_sel = 1'b1; acc_we = we; acc_port = port; acc_wdata = wd; lock_toggle = tgl;
        @(negedge clk);
        acc_sel = 1'b0; acc_we = 1'b0; lock_toggle = 2'b00;
        if (exp_v && known)
            check(rd_valid == 1'b1 && rd_data == exp_d, req, "read",
                  {rd_valid, rd_data}, {1'b1, exp_d});
        else
            check(rd_valid == exp_v, req, "valid", rd_valid, exp_v);
        if (we) begin
            case (port)
                2'd0: m_addr = (m_addr & 32'hFF00) | wd;
                2'd1: m_addr = (m_addr & 32'h00FF) | (int'(wd) << 8);
                2'd3: begin
                    if (c == 0) m_mem[m_addr] = wd;
                    m_addr = 0;
                end
                default: ;
            endcase
        end
        m_lock = m_lock ^ tgl;
    endtask

    task automatic idle(input logic [1:0] tgl, input string req);
        lock_toggle = tgl;
        @(negedge clk);
        lock_toggle = 2'b00;
        check(rd_valid == 1'b0, req, "idle valid", rd_valid, 0);
        m_lock = m_lock ^ tgl;
    endtask

    task automatic set_addr(input int a, input string req);
        acc(2'd1, 1'b1, 8'(a >> 8), 2'b00, req);
        acc(2'd0, 1'b1, 8'(a), 2'b00, req);
    endtask

    task automatic poke(input int a, input logic [7:0] d, input string req);
        set_addr(a, req);
        acc(2'd3, 1'b1, d, 2'b00, req);
    endtask

    task automatic peek(input int a, input string req);
        set_addr(a, req);
        acc(2'd3, 1'b0, 8'h00, 2'b00, req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_addr = 0;
        m_lock = 2'b00;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        check(rd_valid == 1'b0, "R10", "reset valid", rd_valid, 0);

        // R1: the high byte survives a rewrite of the low byte
        acc(2'd1, 1'b1, 8'h01, 2'b00, "R1");
        acc(2'd0, 1'b1, 8'h23, 2'b00, "R1");
        acc(2'd0, 1'b1, 8'h45, 2'b00, "R1");
        acc(2'd3, 1'b1, 8'hA5, 2'b00, "R2");
        // R2: the latch is zero, so this write lands at address 0
        acc(2'd3, 1'b1, 8'h3C, 2'b00, "R2");
        peek(0, "R2");
        peek(16'h0145, "R1");
        // R3: a second read with no new address sees the same byte
        acc(2'd3, 1'b0, 8'h00, 2'b00, "R3");
        acc(2'd3, 1'b0, 8'h00, 2'b00, "R3");

        // R4: side ports read all ones; a port-2 write is inert
        acc(2'd0, 1'b0, 8'h00, 2'b00, "R4");
        acc(2'd1, 1'b0, 8'h00, 2'b00, "R4");
        acc(2'd2, 1'b0, 8'h00, 2'b00, "R4");
        acc(2'd2, 1'b1, 8'h77, 2'b00, "R4");
        acc(2'd3, 1'b0, 8'h00, 2'b00, "R4");

        // seed the bytes around both windows
        poke(16'h1F, 8'h1F, "R5");
        poke(16'h20, 8'h20, "R5");
        poke(16'h25, 8'h11, "R5");
        poke(16'h2F, 8'h2F, "R5");
        poke(16'h30, 8'h30, "R6");
        poke(16'h3F, 8'h3F, "R6");
        poke(16'h40, 8'h40, "R6");

        // R5 / R7: toggle on, in the same cycle as a read that still sees it off
        set_addr(16'h25, "R7");
        acc(2'd3, 1'b0, 8'h00, 2'b01, "R7");
        acc(2'd3, 1'b0, 8'h00, 2'b00, "R5");
        acc(2'd3, 1'b1, 8'h99, 2'b00, "R5");
        peek(16'h20, "R5");
        peek(16'h2F, "R5");
        peek(16'h1F, "R5");
        peek(16'h30, "R5");
        idle(2'b01, "R7");
        peek(16'h25, "R5");

        // R6: lock 1 alone
        idle(2'b10, "R7");
        peek(16'h30, "R6");
        poke(16'h3F, 8'hEE, "R6");
        peek(16'h3F, "R6");
        peek(16'h2F, "R6");
        peek(16'h40, "R6");
        idle(2'b10, "R7");
        peek(16'h3F, "R6");

        // R8: beyond the memory
        peek(MEM, "R8");
        poke(MEM, 8'h12, "R8");
        peek(MEM, "R8");
        peek(16'hFFFF, "R8");
        peek(MEM - 1 - 2048 + 2048, "R8");

        // R9: flags and the byte above it read zero; the byte below is storage
        poke(MEM - 16, 8'h5A, "R9");
        peek(MEM - 16, "R9");
        poke(MEM - 15, 8'h6B, "R9");
        peek(MEM - 15, "R9");
        poke(MEM - 17, 8'h7C, "R9");
        peek(MEM - 17, "R9");

        // R10: reset drops the latch and locks, keeps the contents
        idle(2'b11, "R10");
        set_addr(16'h0145, "R10");
        do_reset();
        acc(2'd3, 1'b0, 8'h00, 2'b00, "R10");
        peek(16'h25, "R10");
        peek(16'h3F, "R10");
        peek(16'h0145, "R10");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule